// File: doc/BRIEF.md
# Bit-Serial Unsigned Magnitude Comparator

This block compares two unsigned quantities that reach it one bit per clock on two serial lines, least significant bit first. An external word timing counter supplies the slot number of each bit time. Only the slots that carry the magnitude take part in the comparison. The sign slot and the blank spacing slots are gated off at the input.

A two-flop verdict register holds one of three states: equal, A greater, or A less. A single-cycle clear pulse, normally given in a blank slot ahead of each word, returns the register to equal. Each magnitude slot in which the two bits differ overwrites the verdict. The highest differing bit therefore decides the outcome.

When the sign slot passes, the verdict is copied into a held result. A one-cycle valid strobe marks the copy. The three result flags keep their values until the next word's sign slot.

Top module: `serial_mag_cmp`

## Requirements
- R1: After reset the outputs are eq_o=1, gt_o=0, lt_o=0 and res_valid_o=0.
- R2: Slot s (MAG_LO ≤ s ≤ MAG_HI, defaults 7 and 36) carries magnitude bit s-MAG_LO of each operand. The verdict for a word started with a clear is gt_o when A>B and lt_o when A<B, both taken as unsigned values.
- R3: A differing pair in a later slot overrides the verdict set by any earlier differing pair, so the most significant differing bit decides.
- R4: Equal magnitudes give eq_o=1 with gt_o=0 and lt_o=0.
- R5: Bits presented in the sign slot (SIGN_SLOT, default 37) or in any blank slot do not affect the verdict.
- R6: res_valid_o is high for exactly one cycle per word: the cycle after the clock edge at which slot_i equals SIGN_SLOT. The flags take the new result on that same edge.
- R7: Between strobes, gt_o, lt_o and eq_o hold their values.
- R8: A clr_i pulse returns the verdict to equal. Without the pulse, a word whose magnitudes match keeps the previous verdict.
- R9: Exactly one of gt_o, lt_o and eq_o is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_i | input | 1 | One-cycle clear of the verdict to equal |
| slot_i | input | SLOT_W (6) | Current slot number within the word |
| a_bit_i | input | 1 | Serial bit of operand A |
| b_bit_i | input | 1 | Serial bit of operand B |
| res_valid_o | output | 1 | One-cycle result strobe |
| gt_o | output | 1 | Held flag: A greater than B |
| lt_o | output | 1 | Held flag: A less than B |
| eq_o | output | 1 | Held flag: magnitudes equal |

## Verification
The bench builds the block with its default parameters: a 42-slot word, a magnitude in slots 7 to 36 and the sign in slot 37. These values make full 30-bit operands reachable. They allow words whose only difference is the top bit, against an opposite difference in every lower bit. Random noise is driven into the sign and blank slots. Words are also sent without a clear, to show that the verdict carries over from the previous word.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef enum logic [1:0] {
    VERD_EQ = 2'd0,
    VERD_GT = 2'd1,
    VERD_LT = 2'd2
  } verdict_t;

  function automatic logic [2:0] verdict_flags(verdict_t v);
    logic [2:0] f;
    case (v)
      VERD_GT: f = 3'b100;
      VERD_LT: f = 3'b010;
      default: f = 3'b001;
    endcase
    return f;
  endfunction
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/slot_decode.sv
module slot_decode #(
  parameter int WORD_SLOTS = 42,
  parameter int MAG_LO     = 7,
  parameter int MAG_HI     = 36,
  parameter int SIGN_SLOT  = 37,
  localparam int SLOT_W    = $clog2(WORD_SLOTS)
) (
  input  logic [SLOT_W-1:0] slot_i,
  output logic              mag_en_o,
  output logic              sign_hit_o
);
  always_comb begin
    mag_en_o   = (int'(slot_i) >= MAG_LO) && (int'(slot_i) <= MAG_HI);
    sign_hit_o = (int'(slot_i) == SIGN_SLOT);
  end
endmodule

// File: rtl/input_gate.sv
module input_gate (
  input  logic a_bit_i,
  input  logic b_bit_i,
  input  logic mag_en_i,
  output logic a_g_o,
  output logic b_g_o
);
  always_comb begin
    a_g_o = a_bit_i & mag_en_i;
    b_g_o = b_bit_i & mag_en_i;
  end
endmodule

// File: rtl/cmp_state.sv
module cmp_state
  import cmp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr_i,
  input  logic     mag_en_i,
  input  logic     a_g_i,
  input  logic     b_g_i,
  output verdict_t verd_o
);
  verdict_t verd_q, verd_d;
  logic     upd_en;

  always_comb begin
    upd_en = clr_i | mag_en_i;
    verd_d = verd_q;
    if (clr_i) begin
      verd_d = VERD_EQ;
    end else if (mag_en_i) begin
      case ({a_g_i, b_g_i})
        2'b10:   verd_d = VERD_GT;
        2'b01:   verd_d = VERD_LT;
        default: verd_d = verd_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      verd_q <= VERD_EQ;
    else if (upd_en) verd_q <= verd_d;
  end

  assign verd_o = verd_q;

  // R9
  verd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verd_q != 2'd3);
  // R2
  gt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mag_en_i && a_g_i && !b_g_i && !clr_i) |=> verd_q == VERD_GT);
  // R3
  lt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mag_en_i && !a_g_i && b_g_i && !clr_i) |=> verd_q == VERD_LT);
  // R8
  clr_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> verd_q == VERD_EQ);
  // R5
  masked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mag_en_i && !clr_i) |=> $stable(verd_q));
endmodule

// File: rtl/result_hold.sv
module result_hold
  import cmp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     capture_i,
  input  verdict_t verd_i,
  output logic     valid_o,
  output logic     gt_o,
  output logic     lt_o,
  output logic     eq_o
);
  logic [2:0] flags_q, flags_d;
  logic       valid_q, valid_d;

  always_comb begin
    valid_d = capture_i;
    flags_d = verdict_flags(verd_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flags_q <= 3'b001;
    else if (capture_i) flags_q <= flags_d;
  end

  assign valid_o = valid_q;
  assign gt_o    = flags_q[2];
  assign lt_o    = flags_q[1];
  assign eq_o    = flags_q[0];

  // R9
  flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({gt_o, lt_o, eq_o}) == 1);
  // R6
  strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_i |=> valid_o);
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_i |=> ($stable({gt_o, lt_o, eq_o}) && !valid_o));
endmodule

// File: rtl/serial_mag_cmp.sv
module serial_mag_cmp
  import cmp_pkg::*;
#(
  parameter int WORD_SLOTS  = 42,
  parameter int MAG_LO      = 7,
  parameter int MAG_HI      = 36,
  parameter int SIGN_SLOT   = 37,
  parameter int SYNC_STAGES = 2,
  localparam int SLOT_W     = $clog2(WORD_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              a_bit_i,
  input  logic              b_bit_i,
  output logic              res_valid_o,
  output logic              gt_o,
  output logic              lt_o,
  output logic              eq_o
);
  logic     rst_n_s;
  logic     mag_en, sign_hit;
  logic     a_g, b_g;
  verdict_t verd;

  rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  slot_decode #(
    .WORD_SLOTS(WORD_SLOTS), .MAG_LO(MAG_LO), .MAG_HI(MAG_HI), .SIGN_SLOT(SIGN_SLOT)
  ) u_dec (
    .slot_i(slot_i), .mag_en_o(mag_en), .sign_hit_o(sign_hit)
  );

  input_gate u_gate (
    .a_bit_i(a_bit_i), .b_bit_i(b_bit_i), .mag_en_i(mag_en),
    .a_g_o(a_g), .b_g_o(b_g)
  );

  cmp_state u_state (
    .clk(clk), .rst_n(rst_n_s), .clr_i(clr_i), .mag_en_i(mag_en),
    .a_g_i(a_g), .b_g_i(b_g), .verd_o(verd)
  );

  result_hold u_hold (
    .clk(clk), .rst_n(rst_n_s), .capture_i(sign_hit), .verd_i(verd),
    .valid_o(res_valid_o), .gt_o(gt_o), .lt_o(lt_o), .eq_o(eq_o)
  );
endmodule

// File: tb/serial_mag_cmp_tb.sv
module serial_mag_cmp_tb;
  localparam int WORD_SLOTS = 42;
  localparam int MAG_LO     = 7;
  localparam int MAG_HI     = 36;
  localparam int SIGN_SLOT  = 37;
  localparam int SLOT_W     = $clog2(WORD_SLOTS);
  localparam int MAG_W      = MAG_HI - MAG_LO + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic [SLOT_W-1:0] slot = '0;
  logic a_bit = 1'b0, b_bit = 1'b0;
  logic vld, gt, lt, eq;

  int checks = 0;
  int fails  = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];
  logic [2:0] last_exp = 3'b001;
  logic [2:0] carry_exp = 3'b001;

  always #2 clk = ~clk;

  serial_mag_cmp u_dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .slot_i(slot),
    .a_bit_i(a_bit), .b_bit_i(b_bit), .res_valid_o(vld),
    .gt_o(gt), .lt_o(lt), .eq_o(eq)
  );

  task automatic check(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  function automatic logic [2:0] cmp_exp(input logic [MAG_W-1:0] a, input logic [MAG_W-1:0] b,
                                         input logic [2:0] prev, input bit cleared);
    if (a > b)       return 3'b100;
    else if (a < b)  return 3'b010;
    else if (cleared) return 3'b001;
    else             return prev;
  endfunction

  // driver: pushes expectation, then streams one word
  task automatic send_word(input logic [MAG_W-1:0] a, input logic [MAG_W-1:0] b,
                           input bit use_clr, input string tag);
    carry_exp = cmp_exp(a, b, carry_exp, use_clr);
    exp_q.push_back(carry_exp);
    tag_q.push_back(tag);
    for (int s = 0; s < WORD_SLOTS; s++) begin
      @(posedge clk); #1;
      slot = SLOT_W'(s);
      clr  = use_clr && (s == 0);
      if (s >= MAG_LO && s <= MAG_HI) begin
        a_bit = a[s-MAG_LO];
        b_bit = b[s-MAG_LO];
      end else begin
        a_bit = 1'($urandom);   // noise in sign and blank slots (R5)
        b_bit = 1'($urandom);
      end
    end
  endtask

  // monitor: pops and compares at each strobe, checks hold otherwise
  always @(negedge clk) begin
    if (rst_n) begin
      if (vld) begin
        check(int'(slot) == SIGN_SLOT + 1, "R6 strobe timing", {1'b0, 3'(slot)}, 4'(SIGN_SLOT + 1));
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected strobe", 4'b1, 4'b0);
        end else begin
          last_exp = exp_q.pop_front();
          check({gt, lt, eq} == last_exp, tag_q.pop_front(), {1'b0, gt, lt, eq}, {1'b0, last_exp});
        end
      end else begin
        check({gt, lt, eq} == last_exp, "R7 hold / R9 onehot", {1'b0, gt, lt, eq}, {1'b0, last_exp});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check({vld, gt, lt, eq} == 4'b0001, "R1 reset state", {vld, gt, lt, eq}, 4'b0001);

    send_word(30'd0, 30'd0, 1'b1, "R4 zero equal");
    send_word(30'd1, 30'd0, 1'b1, "R2 lsb greater");
    send_word(30'd0, 30'd1, 1'b1, "R2 lsb less");
    send_word(30'h2000_0000, 30'h1FFF_FFFF, 1'b1, "R3 msb overrides lower");
    send_word(30'd1, 30'd2, 1'b1, "R3 later bit overrides");
    send_word(30'h3FFF_FFFF, 30'h3FFF_FFFF, 1'b1, "R5 equal with noisy sign");
    send_word(30'd3, 30'd1, 1'b1, "R2 greater before carry");
    send_word(30'd7, 30'd7, 1'b0, "R8 no clear keeps greater");
    send_word(30'd7, 30'd7, 1'b1, "R8 clear gives equal");
    send_word(30'd12345, 30'd12345, 1'b1, "R4 mid equal");
    for (int i = 0; i < 20; i++) begin
      logic [MAG_W-1:0] ra, rb;
      ra = MAG_W'($urandom);
      rb = (i % 4 == 0) ? ra : MAG_W'($urandom);
      send_word(ra, rb, 1'b1, "R2 random pair");
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R6 one strobe per word", 4'(exp_q.size()), 4'd0);
    finish_run();
  end
endmodule